// File: doc/BRIEF.md
# Quadrature Position and Revolution Counter

This block decodes the three signals of an incremental encoder: two phases, A and B, and a once-per-turn index, Z. It keeps a 16-bit position count and a 16-bit revolution count. Each encoder input first passes through a two-flop synchronizer, and edges are then detected on the synchronized levels. A control register sets the counting mode and the active edge for each input. The modes are separate up and down inputs, x4 quadrature decoding, and a count input with a separate direction level.

Two compare registers each watch either the position or the revolution counter. When a count update lands the watched counter on the compare value, the matching interrupt output pulses for one cycle. Software sets the mode, the compare values and the counter preloads through a plain write port. The counters and the last counting direction are visible on output pins at all times. The block has no data stream, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `qpos_counter`

## Requirements
- R1: During and after reset, pos_cnt and rev_cnt are 0, cnt_dir is 1 (up), both interrupt outputs are low, and the control register is 0 (up/down mode with every edge disabled).
- R2: An input change that is driven between clock edges moves a counter on the third rising clock edge after the change, never on the second.
- R3: With mode code 00 (up/down), an active A edge adds one to the position and an active B edge subtracts one. Active edges on A and B in the same cycle leave the position unchanged. Mode code 11 counts nothing on A or B.
- R4: With mode code 01 (phase difference), every change of exactly one of A or B moves the position by one, and the A/B edge selections are ignored. The count goes up when new A differs from old B (A leading) and down otherwise. A cycle in which A and B both change leaves the position unchanged.
- R5: With mode code 10 (direction input), an active A edge moves the position by one: up when the synchronized B level is 0, down when it is 1. B edges alone do nothing.
- R6: Each 2-bit edge selection uses the codes 00 none, 01 rising, 10 falling, 11 both. A change that its selection does not cover has no effect.
- R7: An active Z edge sets the position to 0 and moves the revolution count by one in the current direction. The current direction is the direction of a count in the same cycle if there is one, and otherwise the last direction stored in cnt_dir.
- R8: Compare unit k pulses cmpk_irq for one cycle when a count or index update leaves its target counter equal to its compare value. The target is the revolution counter when the unit's select bit is 1 and the position otherwise. Writes never raise the pulse.
- R9: Writes use address 0 for control, with mode in bits 1:0, the A, B and Z edge selections in bits 3:2, 5:4 and 7:6, and the compare-0 and compare-1 target selects in bits 8 and 9. Address 1 holds the compare-0 value, 2 the compare-1 value, 3 loads the position and 4 loads the revolution count. A load takes priority over counting in the same cycle.
- R10: Both counters wrap modulo 2^16: up from 0xFFFF gives 0x0000, and down from 0x0000 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_z | input | 1 | Encoder index (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pos_cnt | output | 16 | Position counter |
| rev_cnt | output | 16 | Revolution counter |
| cnt_dir | output | 1 | Last count direction, 1 = up |
| cmp0_irq | output | 1 | Compare-0 match pulse |
| cmp1_irq | output | 1 | Compare-1 match pulse |

## Verification
The bench checks the exact synchronizer latency, because a design with one flop too many or too few moves a count a cycle early or late. In phase mode it drives simultaneous A and B changes, which a decoder without an illegal-transition guard would count. It drives an index right after a direction reversal, which a design holding a stale direction would count the wrong way. It also covers wrap at 0xFFFF and 0x0000 and compare values that match only after wrap or on the revolution counter. Random walks across every mode and edge selection are checked against a bench model, so a swapped phase formula or a miswired edge code shows up as a position mismatch.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic [1:0] {
    MODE_UPDOWN = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_DIRIN  = 2'b10,
    MODE_OFF    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    EDG_NONE = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  // Packed MSB first: bit 9 .. bit 0
  typedef struct packed {
    logic      cmp1_rev;
    logic      cmp0_rev;
    edge_sel_e z_sel;
    edge_sel_e b_sel;
    edge_sel_e a_sel;
    mode_e     mode;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int REG_CTRL = 0;
  localparam int REG_CMP0 = 1;
  localparam int REG_CMP1 = 2;
  localparam int REG_POS  = 3;
  localparam int REG_REV  = 4;

  function automatic logic edge_hit(edge_sel_e sel, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (sel)
      EDG_RISE: edge_hit = rise;
      EDG_FALL: edge_hit = fall;
      EDG_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/qpos_sync_edge.sv
module qpos_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);

  localparam int LAST = STAGES;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [LAST:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[LAST-1:0], din[i]};
    end
    assign lvl[i] = sh[LAST-1];
    assign prv[i] = sh[LAST];
  end

endmodule

// File: rtl/qpos_step_decode.sv
module qpos_step_decode
  import qpos_pkg::*;
(
  input  ctrl_t      ctrl,
  input  logic [2:0] lvl,
  input  logic [2:0] prv,
  output logic       inc,
  output logic       dec,
  output logic       zhit
);

  logic a_ev, b_ev, a_ch, b_ch, lead_up;

  always_comb begin
    a_ev    = edge_hit(ctrl.a_sel, prv[0], lvl[0]);
    b_ev    = edge_hit(ctrl.b_sel, prv[1], lvl[1]);
    zhit    = edge_hit(ctrl.z_sel, prv[2], lvl[2]);
    a_ch    = lvl[0] ^ prv[0];
    b_ch    = lvl[1] ^ prv[1];
    lead_up = lvl[0] ^ prv[1];
    inc     = 1'b0;
    dec     = 1'b0;
    case (ctrl.mode)
      MODE_UPDOWN: begin
        inc = a_ev & ~b_ev;
        dec = b_ev & ~a_ev;
      end
      MODE_PHASE: begin
        if (a_ch ^ b_ch) begin
          inc = lead_up;
          dec = ~lead_up;
        end
      end
      MODE_DIRIN: begin
        inc = a_ev & ~lvl[1];
        dec = a_ev & lvl[1];
      end
      default: begin
        inc = 1'b0;
        dec = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/qpos_counter_core.sv
module qpos_counter_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         zhit,
  input  logic         ld_pos,
  input  logic         ld_rev,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] pos_q,
  output logic [W-1:0] rev_q,
  output logic         dir_q,
  output logic [W-1:0] pos_nxt,
  output logic [W-1:0] rev_nxt,
  output logic         upd
);

  localparam logic [W-1:0] ONE = W'(1);
  logic dir_eff;

  always_comb begin
    dir_eff = inc ? 1'b1 : (dec ? 1'b0 : dir_q);
    pos_nxt = pos_q;
    if (inc)      pos_nxt = pos_q + ONE;
    else if (dec) pos_nxt = pos_q - ONE;
    if (zhit)     pos_nxt = '0;
    rev_nxt = rev_q;
    if (zhit)     rev_nxt = dir_eff ? rev_q + ONE : rev_q - ONE;
    upd = inc | dec | zhit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      rev_q <= '0;
      dir_q <= 1'b1;
    end else begin
      pos_q <= ld_pos ? ld_val : pos_nxt;
      rev_q <= ld_rev ? ld_val : rev_nxt;
      dir_q <= dir_eff;
    end
  end

endmodule

// File: rtl/qpos_compare.sv
module qpos_compare #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic [W-1:0]        pos_nxt,
  input  logic [W-1:0]        rev_nxt,
  input  logic [N-1:0][W-1:0] cmp_val,
  input  logic [N-1:0]        sel_rev,
  output logic [N-1:0]        irq
);

  for (genvar k = 0; k < N; k++) begin : g_cmp
    logic [W-1:0] tgt;
    assign tgt = sel_rev[k] ? rev_nxt : pos_nxt;
    always_ff @(posedge clk) begin
      if (!rst_n) irq[k] <= 1'b0;
      else        irq[k] <= upd && (tgt == cmp_val[k]);
    end
  end

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_z,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  pos_cnt,
  output logic [CNT_W-1:0]  rev_cnt,
  output logic              cnt_dir,
  output logic              cmp0_irq,
  output logic              cmp1_irq
);

  localparam int NCMP = 2;

  ctrl_t                      ctrl_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [2:0]                 lvl, prv;
  logic                       inc, dec, zhit;
  logic                       ld_pos, ld_rev, upd, upd_irq;
  logic [CNT_W-1:0]           pos_nxt, rev_nxt;
  logic [NCMP-1:0]            irq;

  assign ld_pos = wr_en && (wr_addr == ADDR_W'(REG_POS));
  assign ld_rev = wr_en && (wr_addr == ADDR_W'(REG_REV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_CTRL)) ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == ADDR_W'(REG_CMP0)) cmp_q[0] <= wr_data;
      if (wr_addr == ADDR_W'(REG_CMP1)) cmp_q[1] <= wr_data;
    end
  end

  qpos_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({enc_z, enc_b, enc_a}),
    .lvl (lvl),
    .prv (prv)
  );

  qpos_step_decode u_dec (
    .ctrl (ctrl_q),
    .lvl (lvl),
    .prv (prv),
    .inc (inc),
    .dec (dec),
    .zhit (zhit)
  );

  qpos_counter_core #(.W(CNT_W)) u_core (
    .clk (clk),
    .rst_n (rst_n),
    .inc (inc),
    .dec (dec),
    .zhit (zhit),
    .ld_pos (ld_pos),
    .ld_rev (ld_rev),
    .ld_val (wr_data),
    .pos_q (pos_cnt),
    .rev_q (rev_cnt),
    .dir_q (cnt_dir),
    .pos_nxt (pos_nxt),
    .rev_nxt (rev_nxt),
    .upd (upd)
  );

  assign upd_irq = upd & ~ld_pos & ~ld_rev;

  qpos_compare #(.W(CNT_W), .N(NCMP)) u_cmp (
    .clk (clk),
    .rst_n (rst_n),
    .upd (upd_irq),
    .pos_nxt (pos_nxt),
    .rev_nxt (rev_nxt),
    .cmp_val (cmp_q),
    .sel_rev ({ctrl_q.cmp1_rev, ctrl_q.cmp0_rev}),
    .irq (irq)
  );

  assign cmp0_irq = irq[0];
  assign cmp1_irq = irq[1];

endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk
  import qpos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input ctrl_t            ctrl_q,
  input logic [1:0][CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] pos_cnt,
  input logic [CNT_W-1:0] rev_cnt,
  input logic             cmp0_irq,
  input logic             cmp1_irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R8
  cmp0_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp0_irq |-> ((ctrl_q.cmp0_rev ? rev_cnt : pos_cnt) == cmp_q[0]));

  // R8
  cmp1_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp1_irq |-> ((ctrl_q.cmp1_rev ? rev_cnt : pos_cnt) == cmp_q[1]));

  // R10
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (pos_cnt == $past(pos_cnt) || pos_cnt == $past(pos_cnt) + ONE ||
                pos_cnt == $past(pos_cnt) - ONE || pos_cnt == '0));

  // R7
  rev_with_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rev_cnt == $past(rev_cnt) || pos_cnt == '0));

  // R3
  mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctrl_q.mode == MODE_OFF) |=> (pos_cnt == $past(pos_cnt) || pos_cnt == '0));

endmodule

bind qpos_counter qpos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .ctrl_q (ctrl_q),
  .cmp_q (cmp_q),
  .pos_cnt (pos_cnt),
  .rev_cnt (rev_cnt),
  .cmp0_irq (cmp0_irq),
  .cmp1_irq (cmp1_irq)
);

// File: tb/qpos_counter_tb_top.sv
module qpos_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] pos_cnt, rev_cnt;
  logic        cnt_dir, cmp0_irq, cmp1_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [1:0]  m_mode, m_as, m_bs, m_zs;
  logic        m_c0r, m_c1r, m_dir;
  logic [15:0] m_pos, m_rev, m_cmp0, m_cmp1;
  int          e_irq0, e_irq1;

  always #4 clk = ~clk;

  qpos_counter dut_i (
    .clk (clk), .rst_n (rst_n),
    .enc_a (enc_a), .enc_b (enc_b), .enc_z (enc_z),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .pos_cnt (pos_cnt), .rev_cnt (rev_cnt), .cnt_dir (cnt_dir),
    .cmp0_irq (cmp0_irq), .cmp1_irq (cmp1_irq)
  );

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic bit hit(logic [1:0] s, logic o, logic n);
    if (s == 2'b11) return o != n;
    if (s == 2'b01) return !o && n;
    if (s == 2'b10) return o && !n;
    return 0;
  endfunction

  task automatic wr(int addr, logic [15:0] d);
    wr_en = 1; wr_addr = 3'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (addr)
      0: begin m_mode = d[1:0]; m_as = d[3:2]; m_bs = d[5:4]; m_zs = d[7:6];
               m_c0r = d[8]; m_c1r = d[9]; end
      1: m_cmp0 = d;
      2: m_cmp1 = d;
      3: m_pos = d;
      4: m_rev = d;
      default: ;
    endcase
  endtask

  // Apply new input levels, update model, wait and compare
  task automatic step(logic na, logic nb, logic nz, string tag);
    bit up = 0, dn = 0, zh, ch = 0;
    int g0 = 0, g1 = 0;
    case (m_mode)
      2'b00: begin
        up = hit(m_as, enc_a, na) && !hit(m_bs, enc_b, nb);
        dn = hit(m_bs, enc_b, nb) && !hit(m_as, enc_a, na);
      end
      2'b01: if ((enc_a != na) ^ (enc_b != nb)) begin
        up = na ^ enc_b; dn = !(na ^ enc_b);
      end
      2'b10: if (hit(m_as, enc_a, na)) begin up = !nb; dn = nb; end
      default: ;
    endcase
    zh = hit(m_zs, enc_z, nz);
    if (up) begin m_pos = m_pos + 16'd1; m_dir = 1; ch = 1; end
    if (dn) begin m_pos = m_pos - 16'd1; m_dir = 0; ch = 1; end
    if (zh) begin
      m_pos = 0; m_rev = m_dir ? m_rev + 16'd1 : m_rev - 16'd1; ch = 1;
    end
    e_irq0 = (ch && (m_c0r ? m_rev : m_pos) == m_cmp0) ? 1 : 0;
    e_irq1 = (ch && (m_c1r ? m_rev : m_pos) == m_cmp1) ? 1 : 0;
    enc_a = na; enc_b = nb; enc_z = nz;
    repeat (5) begin
      @(negedge clk);
      g0 += int'(cmp0_irq); g1 += int'(cmp1_irq);
    end
    check({tag, " pos"}, int'(pos_cnt), int'(m_pos));
    check({tag, " rev"}, int'(rev_cnt), int'(m_rev));
    check({tag, " dir"}, int'(cnt_dir), int'(m_dir));
    check("R8 irq0", g0, e_irq0);
    check("R8 irq1", g1, e_irq1);
  endtask

  function automatic logic [15:0] cfg(logic [1:0] md, logic [1:0] a, logic [1:0] b,
                                      logic [1:0] z, bit c0, bit c1);
    return {6'd0, c1, c0, z, b, a, md};
  endfunction

  initial begin
    m_mode = 0; m_as = 0; m_bs = 0; m_zs = 0; m_c0r = 0; m_c1r = 0; m_dir = 1;
    m_pos = 0; m_rev = 0; m_cmp0 = 0; m_cmp1 = 0;
    repeat (4) @(negedge clk);
    check("R1 pos", int'(pos_cnt), 0);
    check("R1 rev", int'(rev_cnt), 0);
    check("R1 dir", int'(cnt_dir), 1);
    check("R1 irq", int'({cmp0_irq, cmp1_irq}), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: control is zero, edges disabled: toggles do nothing
    step(1, 0, 0, "R1 ctrl0");
    step(0, 0, 0, "R1 ctrl0");

    // R2 latency: A rising counts up
    wr(0, cfg(2'b00, 2'b01, 2'b01, 2'b00, 0, 0));
    wr(2, 16'h7777);
    wr(1, 16'h7777);
    enc_a = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 early", int'(pos_cnt), 0);
    @(negedge clk);
    check("R2 third", int'(pos_cnt), 1);
    m_pos = 1; m_dir = 1;
    repeat (3) @(negedge clk);
    // R3 up/down
    step(0, 0, 0, "R3 fall ignored");
    step(0, 1, 0, "R3 B down");
    step(0, 0, 0, "R3");
    step(1, 1, 0, "R3 both");
    step(0, 0, 0, "R3");
    // R6 falling-only and none
    wr(0, cfg(2'b00, 2'b10, 2'b00, 2'b00, 0, 0));
    step(1, 1, 0, "R6 rise on fall-sel");
    step(0, 0, 0, "R6 fall");
    step(0, 1, 0, "R6 none");
    step(0, 0, 0, "R6 none");
    // R4 phase: forward, reverse, illegal
    wr(0, cfg(2'b01, 2'b00, 2'b00, 2'b00, 0, 0));
    step(1, 0, 0, "R4 fwd"); step(1, 1, 0, "R4 fwd");
    step(0, 1, 0, "R4 fwd"); step(0, 0, 0, "R4 fwd");
    step(0, 1, 0, "R4 rev"); step(1, 1, 0, "R4 rev");
    step(0, 0, 0, "R4 illegal"); step(1, 1, 0, "R4 illegal");
    // R5 direction mode
    wr(0, cfg(2'b10, 2'b01, 2'b11, 2'b01, 0, 0));
    step(0, 0, 0, "R5");
    step(1, 0, 0, "R5 up");
    step(1, 1, 0, "R5 B edge only");
    step(0, 1, 0, "R5");
    step(1, 1, 0, "R5 down");
    // R7 index after reversal
    step(1, 1, 1, "R7 index dn");
    step(0, 0, 0, "R7");
    step(1, 0, 0, "R7 up");
    step(1, 0, 0, "R7");
    step(1, 0, 1, "R7 low");
    step(1, 0, 0, "R7 fall no");
    step(0, 0, 1, "R7 index up");
    // R10 wrap, R9 loads
    wr(0, cfg(2'b00, 2'b11, 2'b11, 2'b10, 0, 1));
    wr(3, 16'hFFFF);
    check("R9 load pos", int'(pos_cnt), 16'hFFFF);
    wr(4, 16'h0000);
    check("R9 load rev", int'(rev_cnt), 0);
    wr(1, 16'h0000);
    wr(2, 16'hFFFF);
    step(1, 0, 1, "R10 up wrap");
    step(1, 1, 1, "R10 down wrap");
    step(1, 1, 0, "R10 rev wrap");
    // R3 reserved mode
    wr(0, cfg(2'b11, 2'b11, 2'b11, 2'b00, 0, 0));
    step(0, 0, 0, "R3 off");
    step(1, 1, 0, "R3 off");

    // random walk
    for (int i = 0; i < 400; i++) begin
      logic na, nb, nz;
      int r;
      if (i % 40 == 0) begin
        wr(0, cfg(2'($urandom_range(0, 3)), 2'($urandom), 2'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom)));
        wr(1, m_pos + 16'($urandom_range(0, 4)) - 16'd2);
        wr(2, m_rev + 16'($urandom_range(0, 2)) - 16'd1);
      end
      na = enc_a; nb = enc_b; nz = enc_z;
      r = $urandom_range(0, 9);
      if (r < 4) na = !na;
      else if (r < 8) nb = !nb;
      else if (r == 8) nz = !nz;
      else begin na = !na; nb = !nb; end
      case (m_mode)
        2'b00:   step(na, nb, nz, "R3 rand");
        2'b01:   step(na, nb, nz, "R4 rand");
        2'b10:   step(na, nb, nz, "R5 rand");
        default: step(na, nb, nz, "R6 rand");
      endcase
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule